// File: doc/BRIEF.md
# Serial Peripheral Master with Mode Register

A register-mapped master for a four-wire serial peripheral bus. Software sets a 32-bit mode word that selects the clock idle level and phase, the bit order, the character length, the clock prescale, internal loopback and an alternate data-alignment scheme. While the block is enabled and acting as master, each write to the transmit register sends one character. The received character is returned in the receive register. Two event flags report completion, and they can raise an interrupt through a mask register.

Chip selects come from elsewhere, so the block only drives the serial clock and data-out and samples data-in. The intended use is to clear the enable bit, write the new mode, then write one character at a time. Software waits for the received-word flag before reading the result and clearing the flags.

Top module: `spi_mode_ctrl`

## Requirements
- R1: Out of reset, the mode, mask and event registers all read 0, and `sclk` is low.
- R2: The character length is taken from mode bits 23:20. A code c from 1 to 15 means c+1 bits, and code 0 means 32 bits. A transfer produces exactly two serial-clock edges per bit.
- R3: When mode bit 26 is 1, the most significant bit goes first on both `mosi` and `miso`. When it is 0, the least significant bit goes first.
- R4: Mode bit 29 sets the level of `sclk` between transfers. Mode bit 28 selects the sampling edge. With bit 28 at 0, data is sampled on the first edge of each bit and changed on the second. With bit 28 at 1, data is changed on the first edge and sampled on the second.
- R5: When mode bit 30 is 1, the data-in path takes the block's own `mosi` and ignores `miso`.
- R6: With mode bit 14 at 1 and a length below 32, data is placed at fixed positions.
  - MSB-first, 8 bits or fewer: transmit from bits 31:24, receive at bit 16.
  - MSB-first, 9 to 16 bits: transmit from bit 16, receive at bit 16.
  - LSB-first, 8 bits or fewer: transmit from bit 0, receive at bit 8.
  - LSB-first, more than 8 bits: transmit from bit 0, receive at bit 0.
  - With bit 14 at 0, or at 32 bits, both transmit and receive use bit 0 upward.
- R7: The event register (offset 0x24) has two flags. Bit 9 is set when a received word is ready. Bit 8 is set when the transmitter is free again. Both flags are set at the end of a transfer, and bit 8 is cleared when a transfer starts. Writing 1 to an event bit clears it.
- R8: `irq` is high exactly when some event bit is set whose bit in the mask register (offset 0x28) is also set.
- R9: A write to the transmit register (0x30) starts a transfer only if all of these hold: enable (bit 24) is 1, master (bit 25) is 1, the length code is not 1 or 2, and no transfer is running. Any other such write is ignored.
- R10: While enable is 1, a mode write (0x20) changes only the enable bit. Clearing enable stops a running transfer without setting bit 9, and returns `sclk` to its idle level.
- R11: Each half period of `sclk` lasts (p+1) system clocks, where p is mode bits 19:16. The half period is 16 times longer when mode bit 27 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address (mode 0x20, event 0x24, mask 0x28, command 0x2C, transmit 0x30, receive 0x34) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The loopback pass covers every legal length, both bit orders and both alignment settings. It compares the receive register with the transmit value placed per R6, which separates errors in field placement from errors in shift direction. A slave model on the pins runs all four clock idle-level and phase pairs with an independent return word. This catches a mis-timed sample or a swapped edge that loopback would hide. Directed cases cover the following:
- flag clearing and masking;
- writes to the transmit register during a transfer and with an illegal length code;
- frozen mode fields;
- aborts;
- two prescale settings, checked by counting clocks between `sclk` edges.

// File: rtl/spi_mc_pkg.sv
// Shared constants and helpers for the serial master: register offsets,
// mode/event bit positions and the character length decode.
package spi_mc_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] A_MODE = 6'h20;
    localparam logic [ADDR_W-1:0] A_EVT  = 6'h24;
    localparam logic [ADDR_W-1:0] A_MASK = 6'h28;
    localparam logic [ADDR_W-1:0] A_CMD  = 6'h2C;
    localparam logic [ADDR_W-1:0] A_TX   = 6'h30;
    localparam logic [ADDR_W-1:0] A_RX   = 6'h34;

    localparam int B_LOOP  = 30;
    localparam int B_CPOL  = 29;
    localparam int B_CPHA  = 28;
    localparam int B_DIV16 = 27;
    localparam int B_MSB   = 26;
    localparam int B_MAST  = 25;
    localparam int B_EN    = 24;
    localparam int B_LEN   = 20;
    localparam int B_PM    = 16;
    localparam int B_ALIGN = 14;
    localparam int B_NE    = 9;
    localparam int B_NF    = 8;

    localparam logic [31:0] MODE_WMASK = 32'h7FFF_4000;
    localparam logic [31:0] EVT_WMASK  = 32'h0000_0300;

    // Number of bits per character for a length code (0 means 32).
    function automatic logic [5:0] word_bits(input logic [3:0] code);
        return (code == 4'd0) ? 6'd32 : ({2'b00, code} + 6'd1);
    endfunction

    // Codes 1 and 2 would give 2 or 3 bits, which are not supported.
    function automatic logic len_legal(input logic [3:0] code);
        return !(code == 4'd1 || code == 4'd2);
    endfunction

    // Mask with the low n bits set.
    function automatic logic [31:0] low_mask(input logic [5:0] n);
        return (n >= 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction
endpackage

// File: rtl/spi_mc_align.sv
// Data placement between the 32-bit data registers and the right-justified
// character handled by the shift engine. Purely combinational.
// Assumes nbits is a legal length (4..16 or 32) and rx_raw is already masked.
module spi_mc_align
    import spi_mc_pkg::*;
(
    input  logic        align,
    input  logic        msb,
    input  logic [5:0]  nbits,
    input  logic [31:0] tx_reg,
    input  logic [31:0] rx_raw,
    output logic [31:0] tx_raw,
    output logic [31:0] rx_reg
);
    logic [31:0] m;

    // Select transmit source bits and receive destination per alignment mode.
    always_comb begin
        m = low_mask(nbits);
        if (!align || nbits == 6'd32) begin
            tx_raw = tx_reg & m;
            rx_reg = rx_raw;
        end else if (msb) begin
            tx_raw = (nbits <= 6'd8) ? ((tx_reg >> 24) & m) : ((tx_reg >> 16) & m);
            rx_reg = rx_raw << 16;
        end else begin
            tx_raw = tx_reg & m;
            rx_reg = (nbits <= 6'd8) ? (rx_raw << 8) : rx_raw;
        end
    end
endmodule

// File: rtl/spi_mc_engine.sv
// Shift engine: generates the serial clock from the prescale settings,
// shifts a right-justified character out and one in, in either order and
// with either clock phase. Assumes mode inputs are stable while busy.
module spi_mc_engine #(
    parameter int DW   = 32,
    parameter int PM_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic [5:0]      nbits,
    input  logic            msb,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            loop,
    input  logic [PM_W-1:0] pm,
    input  logic            div16,
    input  logic [DW-1:0]   tx_raw,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rx_raw
);
    localparam int CNT_W  = PM_W + 5;
    localparam int EDGE_W = $clog2(DW) + 2;

    logic [CNT_W-1:0]  div_cnt, half_len, half_last;
    logic [EDGE_W-1:0] edge_idx, last_edge;
    logic [DW-1:0]     tx_sr, rx_sr;
    logic              ph, sin, is_sample, is_shift;

    // Derive half period length, edge schedule and serial input.
    always_comb begin
        half_len  = div16 ? ((CNT_W'(pm) + CNT_W'(1)) << 4) : (CNT_W'(pm) + CNT_W'(1));
        half_last = half_len - CNT_W'(1);
        last_edge = {EDGE_W'(nbits), 1'b0}[EDGE_W-1:0] - EDGE_W'(1);
        mosi      = msb ? tx_sr[DW-1] : tx_sr[0];
        sin       = loop ? mosi : miso;
        is_sample = (edge_idx[0] == cpha);
        is_shift  = !is_sample && !(cpha && edge_idx == '0);
        sclk      = ph ^ cpol;
        rx_raw    = msb ? rx_sr : (rx_sr >> (6'd32 - nbits));
    end

    // Transfer sequencer: load, count half periods, sample and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            edge_idx <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            ph       <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
                ph   <= 1'b0;
            end else if (start) begin
                busy     <= 1'b1;
                ph       <= 1'b0;
                div_cnt  <= '0;
                edge_idx <= '0;
                rx_sr    <= '0;
                tx_sr    <= msb ? (tx_raw << (6'd32 - nbits)) : tx_raw;
            end else if (busy) begin
                if (div_cnt == half_last) begin
                    div_cnt  <= '0;
                    ph       <= ~ph;
                    edge_idx <= edge_idx + EDGE_W'(1);
                    if (is_sample)
                        rx_sr <= msb ? {rx_sr[DW-2:0], sin} : {sin, rx_sr[DW-1:1]};
                    if (is_shift)
                        tx_sr <= msb ? (tx_sr << 1) : (tx_sr >> 1);
                    if (edge_idx == last_edge) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    div_cnt <= div_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_mc_regs.sv
// Register file: mode, event, mask, command, transmit and receive words,
// transfer start qualification and interrupt. Assumes single-cycle
// register writes; reads are combinational.
module spi_mc_regs
    import spi_mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [31:0]       rx_in,
    output logic [31:0]       mode_q,
    output logic [31:0]       event_q,
    output logic [31:0]       txd_q,
    output logic              start_q,
    output logic              irq
);
    logic [31:0] mask_q, cmd_q, rx_q, event_d;
    logic        wr, accept;

    // Decode writes and decide whether a transmit write starts a transfer.
    always_comb begin
        wr     = bus_sel && bus_wr;
        accept = wr && bus_addr == A_TX && mode_q[B_EN] && mode_q[B_MAST]
               && len_legal(mode_q[B_LEN +: 4]) && !busy && !start_q;
        event_d = event_q;
        if (wr && bus_addr == A_EVT)
            event_d = event_d & ~bus_wdata;
        if (start_q)
            event_d[B_NF] = 1'b0;
        if (done) begin
            event_d[B_NE] = 1'b1;
            event_d[B_NF] = 1'b1;
        end
        irq = |(event_q & mask_q);
    end

    // Register state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            mask_q  <= '0;
            cmd_q   <= '0;
            event_q <= '0;
            txd_q   <= '0;
            rx_q    <= '0;
            start_q <= 1'b0;
        end else begin
            event_q <= event_d & EVT_WMASK;
            start_q <= accept;
            if (accept)
                txd_q <= bus_wdata;
            if (done)
                rx_q <= rx_in;
            if (wr && bus_addr == A_MODE) begin
                if (mode_q[B_EN])
                    mode_q[B_EN] <= bus_wdata[B_EN];
                else
                    mode_q <= bus_wdata & MODE_WMASK;
            end
            if (wr && bus_addr == A_MASK)
                mask_q <= bus_wdata & EVT_WMASK;
            if (wr && bus_addr == A_CMD)
                cmd_q <= bus_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = mode_q;
            A_EVT:   bus_rdata = event_q;
            A_MASK:  bus_rdata = mask_q;
            A_CMD:   bus_rdata = cmd_q;
            A_TX:    bus_rdata = txd_q;
            A_RX:    bus_rdata = rx_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_mode_ctrl.sv
// Top of the serial master: joins the register file, the data alignment
// and the shift engine. Chip selects are generated outside this block.
module spi_mode_ctrl
    import spi_mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);
    logic [31:0] mode_q, event_q, txd_q, tx_raw, rx_raw, rx_reg;
    logic        start_q, busy, done;
    logic [5:0]  nbits;

    assign nbits = word_bits(mode_q[B_LEN +: 4]);

    spi_mc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .rx_in(rx_reg), .mode_q(mode_q),
        .event_q(event_q), .txd_q(txd_q), .start_q(start_q), .irq(irq)
    );

    spi_mc_align u_align (
        .align(mode_q[B_ALIGN]), .msb(mode_q[B_MSB]), .nbits(nbits),
        .tx_reg(txd_q), .rx_raw(rx_raw), .tx_raw(tx_raw), .rx_reg(rx_reg)
    );

    spi_mc_engine #(.DW(32), .PM_W(4)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start_q), .abort(!mode_q[B_EN]),
        .nbits(nbits), .msb(mode_q[B_MSB]), .cpol(mode_q[B_CPOL]),
        .cpha(mode_q[B_CPHA]), .loop(mode_q[B_LOOP]), .pm(mode_q[B_PM +: 4]),
        .div16(mode_q[B_DIV16]), .tx_raw(tx_raw), .miso(miso), .sclk(sclk),
        .mosi(mosi), .busy(busy), .done(done), .rx_raw(rx_raw)
    );
endmodule

// File: rtl/spi_mode_ctrl_chk.sv
// Property checker for the serial master, attached by bind below.
module spi_mode_ctrl_chk
    import spi_mc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [31:0] mode_q,
    input logic [31:0] event_q,
    input logic [31:0] txd_q,
    input logic        busy,
    input logic        done,
    input logic        start_q,
    input logic        sclk
);
    localparam logic [31:0] NOT_EN = ~(32'h1 << B_EN);

    assert_idle_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == mode_q[B_CPOL]);

    assert_done_sets_ne_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> event_q[B_NE]);

    assert_start_clears_nf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !event_q[B_NF]);

    assert_busy_tx_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_sel && bus_wr && bus_addr == A_TX) |=> $stable(txd_q));

    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[B_EN] && bus_sel && bus_wr && bus_addr == A_MODE)
        |=> (mode_q & NOT_EN) == ($past(mode_q) & NOT_EN));

    assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q[B_EN]) |=> !busy);
endmodule

bind spi_mode_ctrl spi_mode_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .mode_q(mode_q), .event_q(event_q), .txd_q(txd_q),
    .busy(busy), .done(done), .start_q(start_q), .sclk(sclk)
);

// File: tb/spi_mode_ctrl_tb_top.sv
module spi_mode_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi;
    logic        miso = 1'b0;

    int errs = 0, checks = 0;

    localparam logic [5:0] MODE = 6'h20, EVT = 6'h24, MSK = 6'h28, TX = 6'h30, RX = 6'h34;
    localparam logic [31:0] EN = 32'h0100_0000, MAST = 32'h0200_0000, MSB = 32'h0400_0000,
        DIV16 = 32'h0800_0000, CPHA = 32'h1000_0000, CPOL = 32'h2000_0000,
        LOOP = 32'h4000_0000, ALIGN = 32'h0000_4000;

    always #5 clk = ~clk;

    spi_mode_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso));

    // Slave model state
    logic        prev_sclk = 1'b0;
    int          eidx = 0, s_n = 8, gap = 0, last_gap = 0;
    bit          s_msb = 1, s_cpha = 0;
    logic [31:0] s_pat = '0, cap = '0;

    function automatic int wpos(int k);
        return s_msb ? (s_n - 1 - k) : k;
    endfunction

    always @(negedge clk) begin
        gap = gap + 1;
        if (sclk !== prev_sclk) begin
            prev_sclk = sclk;
            last_gap = gap;
            gap = 0;
            if ((eidx % 2) == int'(s_cpha)) begin
                cap[wpos(eidx / 2)] = mosi;
            end else if (!(s_cpha && eidx == 0)) begin
                if ((eidx + 1) / 2 < s_n) miso = s_pat[wpos((eidx + 1) / 2)];
            end
            eidx = eidx + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_ne(string req);
        logic [31:0] ev;
        for (int i = 0; i < 5000; i++) begin
            rd(EVT, ev);
            if (ev[9]) return;
        end
        check(req, 32'hDEAD, 32'h0);
    endtask

    function automatic logic [31:0] lmask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    // R6 placement, computed from the requirement text.
    function automatic logic [31:0] tx_src(logic [31:0] r, int n, bit al, bit m);
        if (!al || n == 32 || !m) return r & lmask(n);
        return (n <= 8) ? ((r >> 24) & lmask(n)) : ((r >> 16) & lmask(n));
    endfunction
    function automatic logic [31:0] rx_dst(logic [31:0] v, int n, bit al, bit m);
        if (!al || n == 32) return v;
        if (m) return v << 16;
        return (n <= 8) ? (v << 8) : v;
    endfunction

    task automatic set_mode(logic [31:0] m);
        wr(MODE, 32'h0);
        wr(MODE, m);
        @(negedge clk);
        prev_sclk = sclk;
    endtask

    task automatic arm(int n, bit m, bit ph, logic [31:0] pat);
        s_n = n; s_msb = m; s_cpha = ph; s_pat = pat; eidx = 0; cap = '0;
        miso = pat[wpos(0)];
    endtask

    // One full transfer with checks on receive word, sent bits and edge count.
    task automatic xfer(string req, logic [31:0] mode, int n, logic [31:0] txw,
                        logic [31:0] pat, logic [31:0] exp_rx);
        logic [31:0] rv;
        bit m;
        m = (mode & MSB) != 0;
        set_mode(mode);
        arm(n, m, (mode & CPHA) != 0, pat);
        wr(TX, txw);
        wait_ne(req);
        rd(RX, rv);
        check(req, rv, exp_rx);
        check({req, " mosi"}, cap, tx_src(txw, n, (mode & ALIGN) != 0, m));
        check("R2 edges", eidx, 2 * n);
        wr(EVT, 32'h300);
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, txw, pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(MODE, v); check("R1 mode", v, 0);
        rd(EVT, v);  check("R1 event", v, 0);
        rd(MSK, v);  check("R1 mask", v, 0);
        check("R1 sclk", sclk, 0);

        // R2 R3 R5 R6 loopback sweep: all legal lengths, both orders, both alignments
        for (int li = 0; li < 14; li++) begin
            for (int o = 0; o < 2; o++) begin
                for (int al = 0; al < 2; al++) begin
                    int n;
                    logic [31:0] md;
                    n = (li == 13) ? 32 : li + 4;
                    md = EN | MAST | LOOP | ((n == 32 ? 0 : n - 1) << 20)
                       | (o ? MSB : 0) | (al ? ALIGN : 0);
                    txw = 32'hA5C3_96E1 ^ (n * 32'h0101_0101) ^ (o * 32'h3C00_00C3);
                    xfer("R6 loopback", md, n, txw, 32'h0,
                         rx_dst(tx_src(txw, n, al != 0, o != 0), n, al != 0, o != 0));
                end
            end
        end

        // R3 R4 pin-level slave, all clock modes, loopback off
        for (int cm = 0; cm < 4; cm++) begin
            foreach (txw[k]) ;
            for (int ni = 0; ni < 3; ni++) begin
                for (int o = 0; o < 2; o++) begin
                    int n;
                    logic [31:0] md;
                    n = (ni == 0) ? 8 : (ni == 1) ? 5 : 32;
                    md = EN | MAST | ((n == 32 ? 0 : n - 1) << 20) | (o ? MSB : 0)
                       | (cm[0] ? CPHA : 0) | (cm[1] ? CPOL : 0);
                    pat = 32'h6D2B_F10C ^ (cm * 32'h1111_0000) ^ (ni * 32'h0000_8421);
                    txw = 32'h1E5A_73B4 ^ (o * 32'hFF00_FF00);
                    xfer("R4 slave", md, n, txw, pat, pat & lmask(n));
                end
            end
        end

        // R7 events and write-one-to-clear, R8 interrupt masking
        set_mode(EN | MAST | LOOP | MSB | (7 << 20));
        wr(TX, 32'h5A);
        wait_ne("R7");
        rd(EVT, v); check("R7 both flags", v, 32'h300);
        check("R8 irq masked off", irq, 0);
        wr(MSK, 32'h200);
        @(negedge clk); check("R8 irq on", irq, 1);
        wr(EVT, 32'h200);
        rd(EVT, v); check("R7 w1c ne", v, 32'h100);
        @(negedge clk); check("R8 irq off", irq, 0);
        wr(MSK, 32'h0);
        wr(TX, 32'h11);
        @(negedge clk);
        rd(EVT, v); check("R7 nf cleared at start", v & 32'h100, 0);
        wait_ne("R7");
        wr(EVT, 32'h300);
        rd(EVT, v); check("R7 w1c both", v, 0);

        // R9 write during transfer ignored
        set_mode(EN | MAST | LOOP | MSB | (3 << 16));
        wr(TX, 32'hCAFE_F00D);
        wr(TX, 32'h1234_5678);
        wait_ne("R9");
        rd(RX, v); check("R9 busy write ignored", v, 32'hCAFE_F00D);
        wr(EVT, 32'h300);
        // R9 illegal length code 2
        set_mode(EN | MAST | LOOP | (2 << 20));
        wr(TX, 32'h7);
        repeat (100) @(negedge clk);
        rd(EVT, v); check("R9 illegal length", v, 0);
        // R9 not master
        set_mode(EN | LOOP | (7 << 20));
        wr(TX, 32'h7);
        repeat (50) @(negedge clk);
        rd(EVT, v); check("R9 not master", v, 0);

        // R10 frozen fields and enable-only writes
        set_mode(EN | MAST | MSB | (7 << 20));
        wr(MODE, EN | MAST | (3 << 20) | LOOP);
        rd(MODE, v); check("R10 frozen", v, EN | MAST | MSB | (7 << 20));
        wr(MODE, 32'h0);
        rd(MODE, v); check("R10 enable only", v, MAST | MSB | (7 << 20));
        wr(MODE, EN | MAST | (3 << 20));
        rd(MODE, v); check("R10 reconfigure", v, EN | MAST | (3 << 20));
        // R10 abort
        set_mode(EN | MAST | LOOP | CPOL | MSB | (3 << 16));
        wr(TX, 32'hFFFF_0000);
        repeat (20) @(negedge clk);
        wr(MODE, 32'h0);
        repeat (300) @(negedge clk);
        rd(EVT, v); check("R10 abort no ne", v & 32'h200, 0);
        check("R10 abort sclk idle", sclk, 1);

        // R11 prescale half periods
        set_mode(EN | MAST | LOOP | (7 << 20) | (5 << 16));
        arm(8, 0, 0, 0);
        wr(TX, 32'h3);
        wait_ne("R11");
        check("R11 pm=5", last_gap, 6);
        wr(EVT, 32'h300);
        set_mode(EN | MAST | LOOP | (7 << 20) | (2 << 16) | DIV16);
        arm(8, 0, 0, 0);
        wr(TX, 32'h3);
        wait_ne("R11");
        check("R11 pm=2 div16", last_gap, 48);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule